// File: doc/BRIEF.md
# Paired-Byte Strobe Sequencer

This block turns a byte stream into timed write cycles on an older parallel peripheral bus. The bus has an 8-bit data path and three write strobes. Bytes arrive over a valid/ready handshake and are grouped in twos. The first byte of a pair is the value to present on the bus. The second byte chooses which strobe, if any, to pulse for that value.

For each pair the block follows a fixed sequence. It drives the data onto the bus and waits a configured setup time. It then asserts the chosen strobe for a configured width. Next it keeps the data unchanged for a configured hold time. Only after that does it take the next pair.

An external flag input paces the commands. It is registered on entry, so a new pair starts only when the flag was high on the previous clock. The strobe outputs are also registered: a strobe chosen as the pulse phase begins shows on its pin at the clock edge that enters that phase.

Top module: `strobe_pair_sequencer`

## Requirements
- R1: Accepted bytes alternate roles. The 1st, 3rd, 5th byte and so on is a data value, and the byte after each one is its control byte. Each data value appears on `bus_data` exactly once, in arrival order.
- R2: Bits [1:0] of the control byte choose the strobe. 00 pulses nothing but still runs the full timing sequence. 01 pulses `strobe_out[0]` (module select), 10 pulses `strobe_out[1]` (register select) and 11 pulses `strobe_out[2]` (data write). Bits [7:2] have no effect. At most one strobe is high at any time.
- R3: `in_ready` is low while a complete pair is waiting to start. A data byte whose control byte has not yet arrived is kept: the bus does not change and no strobe fires until the control byte is accepted.
- R4: The strobe rises exactly S clock cycles after `bus_data` takes the new value, where S is `cfg_setup`, or 1 when `cfg_setup` is 0.
- R5: The strobe stays high for exactly W cycles, where W is `cfg_width`, or 1 when `cfg_width` is 0.
- R6: `bus_data` keeps its value through the hold time. It changes only when the next pair starts. When pairs are queued back to back with the flag high, successive bus changes are exactly S+W+H+1 cycles apart, where H is `cfg_hold`, or 1 when `cfg_hold` is 0.
- R7: A pair starts only if `flag_in` was high at the clock edge before the start. While the flag is low, a waiting pair does not begin. After the flag rises, the bus changes at the second rising clock edge.
- R8: Asserting `rst_n` low clears `strobe_out` and `bus_data` immediately and holds `in_ready` low. Reset also resets the byte phase, so the first byte accepted after reset is a data byte even if a lone data byte arrived before reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Upstream byte is valid |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Block accepts the byte this cycle |
| flag_in | input | 1 | External pacing flag; high allows a new pair to start |
| cfg_setup | input | 8 | Setup cycles from data to strobe (0 acts as 1) |
| cfg_width | input | 8 | Strobe width in cycles (0 acts as 1) |
| cfg_hold | input | 8 | Hold cycles after strobe (0 acts as 1) |
| bus_data | output | 8 | Registered peripheral data bus |
| strobe_out | output | 3 | Registered write strobes: module, register, data |

## Verification
The hardest state to reach from the ports is a half-received pair. This is a data byte that has been accepted and is held while the control byte is missing, and it has to survive a reset so that the byte phase is provably cleared. The stimulus sends a lone data byte and checks that the bus and strobes stay still over a long gap. In a second case it sends a lone data byte, pulses reset, and then sends a full pair whose data byte would be taken as a control byte if the phase had not been cleared. A sweep over every setup, width and hold value from 0 to 3 streams pairs with all four selector codes back to back. In each run, the bench measures setup, width and pair spacing against the arithmetic expectation.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/seq_pair_collect.sv
module seq_pair_collect #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              pop,
  output logic [DATA_W-1:0] pair_data,
  output logic [SEL_W-1:0]  pair_sel,
  output logic              pair_full
);
  logic              run_q;
  logic              phase_q, phase_d;
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q;
  logic [SEL_W-1:0]  sel_q;
  logic              take;
  logic              take_data, take_ctl;

  assign in_ready  = run_q & ~full_q;
  assign take      = in_valid & in_ready;
  assign take_data = take & ~phase_q;
  assign take_ctl  = take & phase_q;

  always_comb begin
    phase_d = phase_q;
    full_d  = full_q;
    if (take) phase_d = ~phase_q;
    if (take_ctl) full_d = 1'b1;
    else if (pop) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      run_q   <= 1'b1;
      phase_q <= phase_d;
      full_q  <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (take_data) data_q <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (take_ctl) sel_q <= in_data[SEL_W-1:0];
  end

  assign pair_data = data_q;
  assign pair_sel  = sel_q;
  assign pair_full = full_q;

  assert_hold_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !pop) |=> (full_q && $stable(data_q) && $stable(sel_q)));

  assert_no_take_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !in_ready);
endmodule

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] eff_val;

  assign eff_val = (load_val == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : load_val;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = eff_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

  assert_load_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q != '0));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SEL_W   = 2,
  parameter int NUM_STB = 3,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_in,
  input  logic              pair_full,
  input  logic [DATA_W-1:0] pair_data,
  input  logic [SEL_W-1:0]  pair_sel,
  output logic              pop,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_width,
  input  logic [CNT_W-1:0]  cfg_hold,
  output logic [DATA_W-1:0] bus_data,
  output logic [NUM_STB-1:0] strobe_out
);
  seq_state_e state_q, state_d;
  logic              flag_q;
  logic [DATA_W-1:0] bus_q;
  logic [SEL_W-1:0]  sel_q;
  logic [NUM_STB-1:0] strobe_q, strobe_d, sel_hot;
  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_val;

  seq_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  for (genvar g = 0; g < NUM_STB; g++) begin : g_dec
    assign sel_hot[g] = (sel_q == SEL_W'(g + 1));
  end

  always_comb begin
    state_d  = state_q;
    pop      = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = cfg_setup;
    unique case (state_q)
      ST_IDLE: begin
        if (pair_full && flag_q) begin
          state_d  = ST_SETUP;
          pop      = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = cfg_setup;
        end
      end
      ST_SETUP: begin
        if (tmr_exp) begin
          state_d  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = cfg_width;
        end
      end
      ST_STROBE: begin
        if (tmr_exp) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = cfg_hold;
        end
      end
      ST_HOLD: begin
        if (tmr_exp) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign strobe_d = (state_d == ST_STROBE) ? sel_hot : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      flag_q   <= 1'b0;
      strobe_q <= '0;
    end else begin
      state_q  <= state_d;
      flag_q   <= flag_in;
      strobe_q <= strobe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      sel_q <= '0;
    end else if (pop) begin
      bus_q <= pair_data;
      sel_q <= pair_sel;
    end
  end

  assign bus_data   = bus_q;
  assign strobe_out = strobe_q;

  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_q));

  assert_strobe_in_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q != '0) |-> (state_q == ST_STROBE));

  assert_bus_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(bus_q));

  assert_start_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP && $past(state_q) == ST_IDLE) |-> ($past(flag_q) && $past(pair_full)));
endmodule

// File: rtl/strobe_pair_sequencer.sv
module strobe_pair_sequencer #(
  parameter int DATA_W  = 8,
  parameter int NUM_STB = 3,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  output logic               in_ready,
  input  logic               flag_in,
  input  logic [CNT_W-1:0]   cfg_setup,
  input  logic [CNT_W-1:0]   cfg_width,
  input  logic [CNT_W-1:0]   cfg_hold,
  output logic [DATA_W-1:0]  bus_data,
  output logic [NUM_STB-1:0] strobe_out
);
  localparam int SEL_W = $clog2(NUM_STB + 1);

  logic              rst_n_int;
  logic              pop, pair_full;
  logic [DATA_W-1:0] pair_data;
  logic [SEL_W-1:0]  pair_sel;

  seq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  seq_pair_collect #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .pop       (pop),
    .pair_data (pair_data),
    .pair_sel  (pair_sel),
    .pair_full (pair_full)
  );

  seq_fsm #(.DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_STB(NUM_STB), .CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .flag_in    (flag_in),
    .pair_full  (pair_full),
    .pair_data  (pair_data),
    .pair_sel   (pair_sel),
    .pop        (pop),
    .cfg_setup  (cfg_setup),
    .cfg_width  (cfg_width),
    .cfg_hold   (cfg_hold),
    .bus_data   (bus_data),
    .strobe_out (strobe_out)
  );
endmodule

// File: tb/test_strobe_pair_sequencer.sv
module test_strobe_pair_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       flag_in = 1'b1;
  logic [7:0] cfg_setup = 8'd1, cfg_width = 8'd1, cfg_hold = 8'd1;
  logic [7:0] bus_data;
  logic [2:0] strobe_out;

  strobe_pair_sequencer i_strobe_pair_sequencer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .flag_in(flag_in), .cfg_setup(cfg_setup),
    .cfg_width(cfg_width), .cfg_hold(cfg_hold), .bus_data(bus_data),
    .strobe_out(strobe_out)
  );

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  int s_eff = 1, w_eff = 1, h_eff = 1;
  bit mon_en = 0, gap_en = 0;
  int t_prev = -1;
  logic [7:0] exp_d[$];
  logic [1:0] exp_s[$];
  logic [7:0] next_d = 8'd1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] hot(input logic [1:0] s);
    return (s == 2'd0) ? 3'b000 : (3'b001 << (s - 1));
  endfunction

  // Monitor: all timing measured in negedges
  int cyc = 0, t_bus = 0, t_rise = 0;
  logic [7:0] p_bus = 8'h00;
  logic [2:0] p_stb = 3'b000;
  logic [1:0] cur_s = 2'd0;
  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (bus_data != p_bus) begin
        if (exp_d.size() == 0) chk(0, "R1 unexpected bus change", bus_data, p_bus);
        else begin
          logic [7:0] ed;
          ed = exp_d.pop_front();
          cur_s = exp_s.pop_front();
          chk(bus_data == ed, "R1 data order", bus_data, ed);
          if (gap_en && t_prev >= 0)
            chk(cyc - t_prev == s_eff + w_eff + h_eff + 1, "R6 pair spacing", cyc - t_prev, s_eff + w_eff + h_eff + 1);
          t_prev = cyc;
          t_bus = cyc;
        end
      end
      if (p_stb == 3'b000 && strobe_out != 3'b000) begin
        chk(strobe_out == hot(cur_s) && cur_s != 2'd0, "R2 strobe select", strobe_out, hot(cur_s));
        chk(cyc - t_bus == s_eff, "R4 setup", cyc - t_bus, s_eff);
        t_rise = cyc;
      end
      if (p_stb != 3'b000 && strobe_out == 3'b000)
        chk(cyc - t_rise == w_eff, "R5 width", cyc - t_rise, w_eff);
    end
    p_bus = bus_data;
    p_stb = strobe_out;
  end

  task automatic send_byte(input logic [7:0] b);
    in_data = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_pair(input logic [7:0] ctl);
    exp_d.push_back(next_d);
    exp_s.push_back(ctl[1:0]);
    send_byte(next_d);
    send_byte(ctl);
    next_d = (next_d == 8'hFF) ? 8'd1 : next_d + 8'd1;
  endtask

  task automatic do_reset;
    mon_en = 0;
    gap_en = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (!in_ready) @(negedge clk);
    mon_en = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] old;
    repeat (2) @(negedge clk);
    // R8 reset state
    chk(strobe_out == 3'b000, "R8 reset strobe", strobe_out, 0);
    chk(bus_data == 8'h00, "R8 reset bus", bus_data, 0);
    chk(in_ready == 1'b0, "R8 reset ready", in_ready, 0);
    rst_n = 1'b1;
    while (!in_ready) @(negedge clk);
    mon_en = 1;

    // Sweep setup/width/hold 0..3, all selector codes, upper bits varied (R2..R6)
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++)
        for (int h = 0; h < 4; h++) begin
          cfg_setup = s[7:0]; cfg_width = w[7:0]; cfg_hold = h[7:0];
          s_eff = (s == 0) ? 1 : s;
          w_eff = (w == 0) ? 1 : w;
          h_eff = (h == 0) ? 1 : h;
          t_prev = -1;
          gap_en = 1;
          for (int k = 0; k < 4; k++) begin
            logic [7:0] ctl;
            ctl = (8'((s * 37 + w * 13 + h * 7 + k * 11)) & 8'hFC) | 8'(k);
            send_pair(ctl);
          end
          repeat (40) @(negedge clk);
          gap_en = 0;
          chk(exp_d.size() == 0, "R1 all pairs issued", exp_d.size(), 0);
        end

    cfg_setup = 8'd2; cfg_width = 8'd2; cfg_hold = 8'd2;
    s_eff = 2; w_eff = 2; h_eff = 2;

    // R3: lone data byte waits for control byte
    old = bus_data;
    exp_d.push_back(next_d);
    exp_s.push_back(2'd3);
    send_byte(next_d);
    repeat (20) @(negedge clk);
    chk(bus_data == old, "R3 lone data no bus change", bus_data, old);
    chk(strobe_out == 3'b000, "R3 lone data no strobe", strobe_out, 0);
    chk(in_ready == 1'b1, "R3 waiting for control", in_ready, 1);
    send_byte(8'hF3);
    next_d = next_d + 8'd1;
    repeat (20) @(negedge clk);
    chk(exp_d.size() == 0, "R3 pair issued after control", exp_d.size(), 0);

    // R7: flag gating
    flag_in = 1'b0;
    old = bus_data;
    send_pair(8'h02);
    repeat (20) @(negedge clk);
    chk(bus_data == old, "R7 flag low blocks start", bus_data, old);
    chk(in_ready == 1'b0, "R3 ready low with full pair", in_ready, 0);
    flag_in = 1'b1;
    @(negedge clk);
    chk(bus_data == old, "R7 flag registered", bus_data, old);
    @(negedge clk);
    chk(bus_data == next_d - 8'd1, "R7 start after flag", bus_data, next_d - 8'd1);
    repeat (20) @(negedge clk);

    // R8: reset mid-strobe clears outputs at once
    cfg_width = 8'd10; w_eff = 10;
    send_pair(8'h01);
    while (strobe_out == 3'b000) @(negedge clk);
    mon_en = 0;
    rst_n = 1'b0;
    #1;
    chk(strobe_out == 3'b000, "R8 async strobe clear", strobe_out, 0);
    chk(bus_data == 8'h00, "R8 async bus clear", bus_data, 0);
    exp_d.delete(); exp_s.delete();
    @(negedge clk);
    do_reset();
    cfg_width = 8'd2; w_eff = 2;

    // R8/R1: byte phase cleared by reset
    send_byte(8'hAA);
    do_reset();
    send_pair(8'h02);
    repeat (20) @(negedge clk);
    chk(exp_d.size() == 0, "R8 phase reset pair issued", exp_d.size(), 0);
    chk(bus_data == next_d - 8'd1, "R8 phase reset data", bus_data, next_d - 8'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule